// File: doc/BRIEF.md
# Indexed Display Controller Register Port

This block is the register front end of a simple display controller. Software reaches it through three 32-bit port offsets. A write to the index port chooses a register number. Later reads and writes on the value port reach that register. The third, auxiliary port is inert. The block holds the identity word, the enable and configured flags, a pending and an active screen size, the cursor controls, a guest identifier and a small scratch bank. It also answers several read-only values that it derives from the fixed host colour depth: the rounded bits per pixel, the bytes per line and the size limits.

Width and height writes land in pending registers. The display pipeline sees the active size, which takes the pending values only when the `apply_size` strobe is high. Rejected writes and accesses to unknown register numbers do not produce messages. Instead, `err_pulse` goes high for one cycle.

Top module: `disp_reg_port`

## Requirements
- R1: Port offsets are byte offsets scaled by ADDR_MUL (default 4): index at 0, value at 1×ADDR_MUL, auxiliary at 2×ADDR_MUL. A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the access. The index port reads back the stored index. The auxiliary port reads 0 and ignores writes. Any other offset reads 0xFFFFFFFF.
- R2: The identity register (index 0) resets to 0x90000002. A write is stored only if the value is 0x90000000, 0x90000001 or 0x90000002. Any other value leaves the register unchanged and raises the error pulse.
- R3: A write to the enable register (index 1) sets the enable flag to (value != 0). In the same write, the configured flag is ANDed with (value != 0), so disabling also clears the configured flag.
- R4: The configured register (index 20) stores (value != 0) on a write and reads the flag back as 0 or 1. The flag drives `cfg_done`.
- R5: Width (index 2) and height (index 3) writes store the low DIM_W bits in pending registers, and these registers read back. `act_width` and `act_height` change only on a cycle with `apply_size` high. They then take the pending values as they stood before that edge, even when a size write happens in the same cycle. They reset to DEF_W and DEF_H.
- R6: The derived read-only registers return these values:
  - index 7 and index 28: (DEPTH+7) & ~7, which is 16 for the default depth of 15;
  - index 12: ((DEPTH+7)>>3) × pending width;
  - index 4 and index 5: MAX_W (2360) and MAX_H (1770);
  - index 6: DEPTH;
  - index 29: SCR_N.
- R7: A write to index 7 whose value equals DEPTH is accepted and changes nothing. Any other value is rejected with the error pulse.
- R8: The capability word (index 17) holds three groups of bits. Bit 0 is CAP_FILL (rectangle fill). Bit 1 is CAP_COPY (rectangle copy). Bits 5, 6 and 7 each equal `cursor_hw`. All other bits are 0.
- R9: Indices 24, 25 and 26 store the cursor ID, X and Y, read back, and drive the cursor outputs. A write to index 27 behaves by value: 1 sets `cursor_vis`, 0 clears it, and any other value (2, 3, ...) leaves it unchanged. Index 27 reads the flag.
- R10: SCR_N scratch words start at index 1792. Each word reads and writes, and each resets to 0.
- R11: An unknown index reads 0, ignores writes and raises the error pulse. A write to a read-only index (4, 5, 6, 12, 17, 22, 28, 29) is ignored with the error pulse. Indices 30 to 32 and 1024 to 1791 read 0 and accept writes without effect or error. A write to index 21 is accepted without effect. Indices 21 and 22 read 0.
- R12: `err_pulse` is high for exactly the cycle after each offending access, and low otherwise.
- R13: The guest identifier (index 23) stores any written value and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_off | input | OFF_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High the cycle after a read |
| apply_size | input | 1 | Copies the pending size into the active size |
| cursor_hw | input | 1 | Hardware cursor present (capability bits 5 to 7) |
| disp_enable | output | 1 | Enable flag |
| cfg_done | output | 1 | Configured flag |
| act_width | output | DIM_W | Active width |
| act_height | output | DIM_W | Active height |
| cursor_id | output | 32 | Cursor identifier |
| cursor_x | output | DIM_W | Cursor X |
| cursor_y | output | DIM_W | Cursor Y |
| cursor_vis | output | 1 | Cursor visible |
| err_pulse | output | 1 | One-cycle rejection or unknown-index flag |

## Verification
Two functions can fall in the same cycle: the apply strobe and a width or height write through the value port. The bench provokes this by raising `apply_size` in the very cycle that writes a new width. It then expects the active width to take the old pending value while the new value waits in the pending register. A second apply then confirms that the new value arrives. A behavioural model that updates on every clock judges all outputs, including the one-cycle error pulse. Directed reads compare each derived value against constants taken from the requirements.

// File: rtl/disp_regs_pkg.sv
package disp_regs_pkg;

    typedef enum logic [4:0] {
        K_ID, K_EN, K_WID, K_HGT, K_MAXW, K_MAXH, K_DEPTH, K_BPP,
        K_BPL, K_CAPS, K_CFG, K_SYNC, K_BUSY, K_GUEST, K_CURID,
        K_CURX, K_CURY, K_CURON, K_HBPP, K_SCRSZ, K_RSVD, K_SCRATCH, K_BAD
    } reg_kind_e;

    // Register numbers that software decodes
    localparam logic [31:0] IX_ID      = 32'd0;
    localparam logic [31:0] IX_EN      = 32'd1;
    localparam logic [31:0] IX_WID     = 32'd2;
    localparam logic [31:0] IX_HGT     = 32'd3;
    localparam logic [31:0] IX_MAXW    = 32'd4;
    localparam logic [31:0] IX_MAXH    = 32'd5;
    localparam logic [31:0] IX_DEPTH   = 32'd6;
    localparam logic [31:0] IX_BPP     = 32'd7;
    localparam logic [31:0] IX_BPL     = 32'd12;
    localparam logic [31:0] IX_CAPS    = 32'd17;
    localparam logic [31:0] IX_CFG     = 32'd20;
    localparam logic [31:0] IX_SYNC    = 32'd21;
    localparam logic [31:0] IX_BUSY    = 32'd22;
    localparam logic [31:0] IX_GUEST   = 32'd23;
    localparam logic [31:0] IX_CURID   = 32'd24;
    localparam logic [31:0] IX_CURX    = 32'd25;
    localparam logic [31:0] IX_CURY    = 32'd26;
    localparam logic [31:0] IX_CURON   = 32'd27;
    localparam logic [31:0] IX_HBPP    = 32'd28;
    localparam logic [31:0] IX_SCRSZ   = 32'd29;
    localparam logic [31:0] IX_RSV_LO  = 32'd30;
    localparam logic [31:0] IX_RSV_HI  = 32'd32;
    localparam logic [31:0] IX_PAL_LO  = 32'd1024;
    localparam logic [31:0] IX_PAL_HI  = 32'd1791;
    localparam logic [31:0] IX_SCR0    = 32'd1792;

    localparam logic [31:0] ID_BASE    = 32'h9000_0000;
    localparam logic [31:0] ID_RESET   = ID_BASE | 32'd2;

    function automatic logic id_is_legal(input logic [31:0] v);
        return (v == ID_BASE) || (v == (ID_BASE | 32'd1)) || (v == (ID_BASE | 32'd2));
    endfunction

    function automatic logic kind_is_readonly(input reg_kind_e k);
        return (k == K_MAXW) || (k == K_MAXH) || (k == K_DEPTH) || (k == K_BPL) ||
               (k == K_CAPS) || (k == K_BUSY) || (k == K_HBPP) || (k == K_SCRSZ);
    endfunction

endpackage

// File: rtl/disp_idx_decode.sv
module disp_idx_decode
    import disp_regs_pkg::*;
#(
    parameter int SCR_N  = 8,
    parameter int SLOT_W = 3
) (
    input  logic [31:0]       idx,
    output reg_kind_e         kind,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [31:0] SCR_END = IX_SCR0 + 32'(SCR_N);

    logic [31:0] rel;

    always_comb begin
        rel  = idx - IX_SCR0;
        slot = rel[SLOT_W-1:0];
        case (idx)
            IX_ID:    kind = K_ID;
            IX_EN:    kind = K_EN;
            IX_WID:   kind = K_WID;
            IX_HGT:   kind = K_HGT;
            IX_MAXW:  kind = K_MAXW;
            IX_MAXH:  kind = K_MAXH;
            IX_DEPTH: kind = K_DEPTH;
            IX_BPP:   kind = K_BPP;
            IX_BPL:   kind = K_BPL;
            IX_CAPS:  kind = K_CAPS;
            IX_CFG:   kind = K_CFG;
            IX_SYNC:  kind = K_SYNC;
            IX_BUSY:  kind = K_BUSY;
            IX_GUEST: kind = K_GUEST;
            IX_CURID: kind = K_CURID;
            IX_CURX:  kind = K_CURX;
            IX_CURY:  kind = K_CURY;
            IX_CURON: kind = K_CURON;
            IX_HBPP:  kind = K_HBPP;
            IX_SCRSZ: kind = K_SCRSZ;
            default: begin
                if ((idx >= IX_RSV_LO && idx <= IX_RSV_HI) ||
                    (idx >= IX_PAL_LO && idx <= IX_PAL_HI))
                    kind = K_RSVD;
                else if (idx >= IX_SCR0 && idx < SCR_END)
                    kind = K_SCRATCH;
                else
                    kind = K_BAD;
            end
        endcase
    end
endmodule

// File: rtl/disp_scratch_bank.sv
module disp_scratch_bank #(
    parameter int SCR_N  = 8,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [31:0]       wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [31:0]       rd_data
);
    logic [31:0] word_q [SCR_N];

    for (genvar g = 0; g < SCR_N; g++) begin : g_word
        logic [31:0] word_d;
        always_comb begin
            word_d = word_q[g];
            if (wr_en && (32'(wr_slot) == g))
                word_d = wr_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) word_q[g] <= '0;
            else        word_q[g] <= word_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (32'(rd_slot) < SCR_N)
            rd_data = word_q[rd_slot];
    end
endmodule

// File: rtl/disp_derived.sv
module disp_derived #(
    parameter int DEPTH = 15,
    parameter int DIM_W = 16
) (
    input  logic [DIM_W-1:0] pend_width,
    output logic [31:0]      bpp_round,
    output logic [31:0]      line_bytes
);
    localparam int ROUNDED   = (DEPTH + 7) & ~7;
    localparam int PIX_BYTES = (DEPTH + 7) >> 3;

    always_comb begin
        bpp_round  = 32'(ROUNDED);
        line_bytes = 32'(PIX_BYTES) * {{(32-DIM_W){1'b0}}, pend_width};
    end
endmodule

// File: rtl/disp_reg_port.sv
module disp_reg_port
    import disp_regs_pkg::*;
#(
    parameter int ADDR_MUL = 4,
    parameter int OFF_W    = 4,
    parameter int DIM_W    = 16,
    parameter int DEPTH    = 15,
    parameter int MAX_W    = 2360,
    parameter int MAX_H    = 1770,
    parameter int DEF_W    = 640,
    parameter int DEF_H    = 480,
    parameter int SCR_N    = 8,
    parameter bit CAP_FILL = 1'b1,
    parameter bit CAP_COPY = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [OFF_W-1:0] bus_off,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             bus_rvalid,
    input  logic             apply_size,
    input  logic             cursor_hw,
    output logic             disp_enable,
    output logic             cfg_done,
    output logic [DIM_W-1:0] act_width,
    output logic [DIM_W-1:0] act_height,
    output logic [31:0]      cursor_id,
    output logic [DIM_W-1:0] cursor_x,
    output logic [DIM_W-1:0] cursor_y,
    output logic             cursor_vis,
    output logic             err_pulse
);
    localparam int SLOT_W = (SCR_N > 1) ? $clog2(SCR_N) : 1;
    localparam logic [OFF_W-1:0] OFF_IDX = OFF_W'(0);
    localparam logic [OFF_W-1:0] OFF_VAL = OFF_W'(ADDR_MUL);
    localparam logic [OFF_W-1:0] OFF_AUX = OFF_W'(2 * ADDR_MUL);

    typedef struct packed {
        logic [31:0]      index;
        logic [31:0]      id;
        logic             en;
        logic             cfg;
        logic [DIM_W-1:0] pw;
        logic [DIM_W-1:0] ph;
        logic [DIM_W-1:0] aw;
        logic [DIM_W-1:0] ah;
        logic [31:0]      guest;
        logic [31:0]      cid;
        logic [DIM_W-1:0] cx;
        logic [DIM_W-1:0] cy;
        logic             con;
        logic [31:0]      rdata;
        logic             rvalid;
        logic             err;
    } st_t;

    st_t st_d, st_q;

    reg_kind_e         kind;
    logic [SLOT_W-1:0] slot;
    logic [31:0]       scr_rd;
    logic              scr_we;
    logic [31:0]       bpp_round, line_bytes;
    logic [31:0]       caps;
    logic [31:0]       reg_val;
    logic              hit_idx, hit_val, hit_aux;
    logic              val_wr, val_rd;

    disp_idx_decode #(.SCR_N(SCR_N), .SLOT_W(SLOT_W)) u_dec (
        .idx (st_q.index),
        .kind(kind),
        .slot(slot)
    );

    disp_scratch_bank #(.SCR_N(SCR_N), .SLOT_W(SLOT_W)) u_scr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (scr_we),
        .wr_slot(slot),
        .wr_data(bus_wdata),
        .rd_slot(slot),
        .rd_data(scr_rd)
    );

    disp_derived #(.DEPTH(DEPTH), .DIM_W(DIM_W)) u_drv (
        .pend_width(st_q.pw),
        .bpp_round (bpp_round),
        .line_bytes(line_bytes)
    );

    always_comb begin
        caps      = '0;
        caps[0]   = CAP_FILL;
        caps[1]   = CAP_COPY;
        caps[7:5] = {3{cursor_hw}};
    end

    // Value-port read mux
    always_comb begin
        case (kind)
            K_ID:      reg_val = st_q.id;
            K_EN:      reg_val = {31'b0, st_q.en};
            K_WID:     reg_val = 32'(st_q.pw);
            K_HGT:     reg_val = 32'(st_q.ph);
            K_MAXW:    reg_val = 32'(MAX_W);
            K_MAXH:    reg_val = 32'(MAX_H);
            K_DEPTH:   reg_val = 32'(DEPTH);
            K_BPP:     reg_val = bpp_round;
            K_HBPP:    reg_val = bpp_round;
            K_BPL:     reg_val = line_bytes;
            K_CAPS:    reg_val = caps;
            K_CFG:     reg_val = {31'b0, st_q.cfg};
            K_GUEST:   reg_val = st_q.guest;
            K_CURID:   reg_val = st_q.cid;
            K_CURX:    reg_val = 32'(st_q.cx);
            K_CURY:    reg_val = 32'(st_q.cy);
            K_CURON:   reg_val = {31'b0, st_q.con};
            K_SCRSZ:   reg_val = 32'(SCR_N);
            K_SCRATCH: reg_val = scr_rd;
            default:   reg_val = '0;
        endcase
    end

    always_comb begin
        hit_idx = (bus_off == OFF_IDX);
        hit_val = (bus_off == OFF_VAL);
        hit_aux = (bus_off == OFF_AUX);
        val_wr  = bus_sel && bus_we && hit_val;
        val_rd  = bus_sel && !bus_we && hit_val;
        scr_we  = val_wr && (kind == K_SCRATCH);

        st_d        = st_q;
        st_d.rvalid = bus_sel && !bus_we;
        st_d.err    = 1'b0;

        if (bus_sel && !bus_we) begin
            if (hit_idx)      st_d.rdata = st_q.index;
            else if (hit_val) st_d.rdata = reg_val;
            else if (hit_aux) st_d.rdata = '0;
            else              st_d.rdata = '1;
        end
        if (val_rd && kind == K_BAD)
            st_d.err = 1'b1;

        // apply samples the pending size held before this edge
        if (apply_size) begin
            st_d.aw = st_q.pw;
            st_d.ah = st_q.ph;
        end

        if (bus_sel && bus_we && hit_idx)
            st_d.index = bus_wdata;

        if (val_wr) begin
            if (kind == K_BAD || kind_is_readonly(kind))
                st_d.err = 1'b1;
            case (kind)
                K_ID: begin
                    if (id_is_legal(bus_wdata)) st_d.id = bus_wdata;
                    else                        st_d.err = 1'b1;
                end
                K_EN: begin
                    st_d.en  = (bus_wdata != 32'd0);
                    st_d.cfg = st_q.cfg && (bus_wdata != 32'd0);
                end
                K_WID:   st_d.pw = bus_wdata[DIM_W-1:0];
                K_HGT:   st_d.ph = bus_wdata[DIM_W-1:0];
                K_BPP: begin
                    if (bus_wdata != 32'(DEPTH)) st_d.err = 1'b1;
                end
                K_CFG:   st_d.cfg   = (bus_wdata != 32'd0);
                K_GUEST: st_d.guest = bus_wdata;
                K_CURID: st_d.cid   = bus_wdata;
                K_CURX:  st_d.cx    = bus_wdata[DIM_W-1:0];
                K_CURY:  st_d.cy    = bus_wdata[DIM_W-1:0];
                K_CURON: begin
                    if (bus_wdata == 32'd1)      st_d.con = 1'b1;
                    else if (bus_wdata == 32'd0) st_d.con = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.id     <= ID_RESET;
            st_q.pw     <= DIM_W'(DEF_W);
            st_q.ph     <= DIM_W'(DEF_H);
            st_q.aw     <= DIM_W'(DEF_W);
            st_q.ah     <= DIM_W'(DEF_H);
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata   = st_q.rdata;
    assign bus_rvalid  = st_q.rvalid;
    assign disp_enable = st_q.en;
    assign cfg_done    = st_q.cfg;
    assign act_width   = st_q.aw;
    assign act_height  = st_q.ah;
    assign cursor_id   = st_q.cid;
    assign cursor_x    = st_q.cx;
    assign cursor_y    = st_q.cy;
    assign cursor_vis  = st_q.con;
    assign err_pulse   = st_q.err;

    // R1: read data is only presented after a read access
    assert_rvalid_after_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_sel && !bus_we));

    // R2: identity register never holds an illegal value
    assert_id_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        id_is_legal(st_q.id));

    // R3: disabling clears the configured flag
    assert_disable_clears_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && kind == K_EN && bus_wdata == 32'd0) |=> !cfg_done);

    // R5: active size moves only with the apply strobe
    assert_size_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_size |=> ($stable(act_width) && $stable(act_height)));

    // R9: codes other than 0 and 1 keep the visible flag
    assert_cursor_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && kind == K_CURON && bus_wdata > 32'd1) |=> $stable(cursor_vis));

    // R12: an error pulse always follows an access
    assert_err_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(bus_sel));

endmodule

// File: tb/sim_disp_reg_port.sv
`timescale 1ns/1ps
module sim_disp_reg_port;
    localparam int DIMW = 16;
    localparam logic [31:0] DMASK = 32'h0000_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0] bus_off = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_rvalid;
    logic apply_size = 1'b0, cursor_hw = 1'b0;
    logic disp_enable, cfg_done, cursor_vis, err_pulse;
    logic [DIMW-1:0] act_width, act_height, cursor_x, cursor_y;
    logic [31:0] cursor_id;

    always #2 clk = ~clk;

    disp_reg_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .apply_size(apply_size), .cursor_hw(cursor_hw),
        .disp_enable(disp_enable), .cfg_done(cfg_done), .act_width(act_width),
        .act_height(act_height), .cursor_id(cursor_id), .cursor_x(cursor_x),
        .cursor_y(cursor_y), .cursor_vis(cursor_vis), .err_pulse(err_pulse)
    );

    int total = 0, bad = 0, cycles = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference ----------------
    logic [31:0] m_index, m_id, m_guest, m_cid, m_rdata;
    logic [31:0] m_pw, m_ph, m_aw, m_ah, m_cx, m_cy;
    logic m_en, m_cfg, m_con, m_rvalid, m_err;
    logic [31:0] m_scr [8];

    function automatic bit is_ro(input logic [31:0] ix);
        return ix == 4 || ix == 5 || ix == 6 || ix == 12 || ix == 17 ||
               ix == 22 || ix == 28 || ix == 29;
    endfunction

    function automatic bit is_known(input logic [31:0] ix);
        if (ix <= 7 || ix == 12 || ix == 17) return 1;
        if (ix >= 20 && ix <= 32) return 1;
        if (ix >= 1024 && ix < 1800) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] m_read(input logic [31:0] ix);
        logic [31:0] c;
        c = 32'h3 | (cursor_hw ? 32'hE0 : 32'h0);
        case (ix)
            0: return m_id;
            1: return {31'b0, m_en};
            2: return m_pw;
            3: return m_ph;
            4: return 2360;
            5: return 1770;
            6: return 15;
            7, 28: return 16;
            12: return 2 * m_pw;
            17: return c;
            20: return {31'b0, m_cfg};
            23: return m_guest;
            24: return m_cid;
            25: return m_cx;
            26: return m_cy;
            27: return {31'b0, m_con};
            29: return 8;
            default: begin
                if (ix >= 1792 && ix < 1800) return m_scr[ix - 1792];
                return 0;
            end
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_index = 0; m_id = 32'h9000_0002; m_en = 0; m_cfg = 0;
            m_pw = 640; m_ph = 480; m_aw = 640; m_ah = 480;
            m_guest = 0; m_cid = 0; m_cx = 0; m_cy = 0; m_con = 0;
            m_rdata = 0; m_rvalid = 0; m_err = 0;
            for (int i = 0; i < 8; i++) m_scr[i] = 0;
        end else begin
            m_rvalid = bus_sel && !bus_we;
            m_err = 0;
            if (bus_sel && !bus_we) begin
                case (bus_off)
                    0: m_rdata = m_index;
                    4: begin
                        m_rdata = m_read(m_index);
                        if (!is_known(m_index)) m_err = 1;
                    end
                    8: m_rdata = 0;
                    default: m_rdata = 32'hFFFF_FFFF;
                endcase
            end
            if (apply_size) begin m_aw = m_pw; m_ah = m_ph; end
            if (bus_sel && bus_we && bus_off == 0) m_index = bus_wdata;
            else if (bus_sel && bus_we && bus_off == 4) begin
                if (!is_known(m_index) || is_ro(m_index)) m_err = 1;
                else case (m_index)
                    0: if (bus_wdata == 32'h9000_0000 || bus_wdata == 32'h9000_0001 ||
                           bus_wdata == 32'h9000_0002) m_id = bus_wdata;
                       else m_err = 1;
                    1: begin m_en = bus_wdata != 0; m_cfg = m_cfg && (bus_wdata != 0); end
                    2: m_pw = bus_wdata & DMASK;
                    3: m_ph = bus_wdata & DMASK;
                    7: if (bus_wdata != 15) m_err = 1;
                    20: m_cfg = bus_wdata != 0;
                    23: m_guest = bus_wdata;
                    24: m_cid = bus_wdata;
                    25: m_cx = bus_wdata & DMASK;
                    26: m_cy = bus_wdata & DMASK;
                    27: if (bus_wdata == 1) m_con = 1; else if (bus_wdata == 0) m_con = 0;
                    default: if (m_index >= 1792 && m_index < 1800) m_scr[m_index - 1792] = bus_wdata;
                endcase
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3", {31'b0, disp_enable}, {31'b0, m_en}, "enable");
            chk("R4", {31'b0, cfg_done}, {31'b0, m_cfg}, "cfg_done");
            chk("R5", 32'(act_width), m_aw, "act_width");
            chk("R5", 32'(act_height), m_ah, "act_height");
            chk("R9", cursor_id, m_cid, "cursor_id");
            chk("R9", 32'(cursor_x), m_cx, "cursor_x");
            chk("R9", 32'(cursor_y), m_cy, "cursor_y");
            chk("R9", {31'b0, cursor_vis}, {31'b0, m_con}, "cursor_vis");
            chk("R12", {31'b0, err_pulse}, {31'b0, m_err}, "err_pulse");
            chk("R1", {31'b0, bus_rvalid}, {31'b0, m_rvalid}, "rvalid");
            if (m_rvalid) chk(cur_req, bus_rdata, m_rdata, "rdata model");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic acc(input logic we, input logic [3:0] off, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = we; bus_off = off; bus_wdata = d;
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_sel = 0; bus_we = 0; apply_size = 0;
    endtask

    task automatic rd_off(input logic [3:0] off, input logic [31:0] exp, input string req);
        cur_req = req;
        acc(0, off, 0);
        idle();
        chk(req, bus_rdata, exp, "directed read");
    endtask

    task automatic rd(input logic [31:0] ix, input logic [31:0] exp, input logic exp_err, input string req);
        acc(1, 0, ix);
        rd_off(4, exp, req);
        chk(req, {31'b0, err_pulse}, {31'b0, exp_err}, "read error flag");
    endtask

    task automatic wr(input logic [31:0] ix, input logic [31:0] v, input logic exp_err, input string req);
        cur_req = req;
        acc(1, 0, ix);
        acc(1, 4, v);
        idle();
        chk(req, {31'b0, err_pulse}, {31'b0, exp_err}, "write error flag");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                bad++; total++;
                $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // reset state
        chk("R5", 32'(act_width), 640, "reset width");
        chk("R3", {31'b0, disp_enable}, 0, "reset enable");
        rd_off(0, 0, "R1");
        rd(0, 32'h9000_0002, 0, "R2");
        rd(1, 0, 0, "R3");
        // derived values (R6)
        rd(4, 2360, 0, "R6");
        rd(5, 1770, 0, "R6");
        rd(6, 15, 0, "R6");
        rd(7, 16, 0, "R6");
        rd(28, 16, 0, "R6");
        rd(12, 1280, 0, "R6");
        rd(29, 8, 0, "R6");
        // offsets (R1)
        acc(1, 0, 23);
        rd_off(0, 23, "R1");
        rd_off(8, 0, "R1");
        rd_off(12, 32'hFFFF_FFFF, "R1");
        rd_off(1, 32'hFFFF_FFFF, "R1");
        acc(1, 8, 99); idle();
        rd_off(0, 23, "R1");
        // identity (R2)
        wr(0, 32'h9000_0001, 0, "R2");
        rd(0, 32'h9000_0001, 0, "R2");
        wr(0, 32'h9000_0003, 1, "R2");
        rd(0, 32'h9000_0001, 0, "R2");
        wr(0, 32'h9000_0000, 0, "R2");
        rd(0, 32'h9000_0000, 0, "R2");
        // enable / configured (R3, R4)
        wr(20, 5, 0, "R4");
        rd(20, 1, 0, "R4");
        wr(1, 1, 0, "R3");
        chk("R3", {31'b0, cfg_done}, 1, "cfg kept on enable");
        wr(1, 0, 0, "R3");
        chk("R3", {31'b0, cfg_done}, 0, "cfg cleared on disable");
        wr(20, 1, 0, "R4");
        wr(1, 7, 0, "R3");
        chk("R3", {30'b0, disp_enable, cfg_done}, 3, "enable 7 keeps cfg");
        // pending / active size (R5)
        wr(2, 800, 0, "R5");
        chk("R5", 32'(act_width), 640, "no apply yet");
        rd(2, 800, 0, "R5");
        rd(12, 1600, 0, "R6");
        cur_req = "R5";
        acc(1, 0, 2);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_off = 4; bus_wdata = 1024; apply_size = 1;
        @(posedge clk);
        idle();
        chk("R5", 32'(act_width), 800, "apply takes old pending");
        rd(2, 1024, 0, "R5");
        @(negedge clk); apply_size = 1; @(negedge clk); apply_size = 0;
        chk("R5", 32'(act_width), 1024, "second apply");
        wr(3, 32'h0001_0258, 0, "R5");
        rd(3, 32'h258, 0, "R5");
        // depth write (R7)
        wr(7, 15, 0, "R7");
        wr(7, 16, 1, "R7");
        rd(7, 16, 0, "R7");
        // capabilities (R8)
        rd(17, 32'h3, 0, "R8");
        cursor_hw = 1;
        rd(17, 32'hE3, 0, "R8");
        // cursor (R9)
        wr(24, 32'hABCD_0001, 0, "R9");
        wr(25, 100, 0, "R9");
        wr(26, 200, 0, "R9");
        rd(25, 100, 0, "R9");
        wr(27, 1, 0, "R9");
        chk("R9", {31'b0, cursor_vis}, 1, "show");
        wr(27, 2, 0, "R9");
        wr(27, 3, 0, "R9");
        chk("R9", {31'b0, cursor_vis}, 1, "codes 2/3 keep");
        wr(27, 0, 0, "R9");
        chk("R9", {31'b0, cursor_vis}, 0, "hide");
        wr(27, 3, 0, "R9");
        wr(27, 9, 0, "R9");
        rd(27, 0, 0, "R9");
        // scratch (R10)
        rd(1795, 0, 0, "R10");
        for (int i = 0; i < 8; i++) wr(1792 + i, 32'h5A00_0000 + i, 0, "R10");
        for (int i = 0; i < 8; i++) rd(1792 + i, 32'h5A00_0000 + i, 0, "R10");
        rd(1800, 0, 1, "R10");
        // unknown / reserved (R11)
        rd(40, 0, 1, "R11");
        wr(40, 7, 1, "R11");
        wr(4, 7, 1, "R11");
        rd(4, 2360, 0, "R11");
        wr(31, 7, 0, "R11");
        rd(31, 0, 0, "R11");
        wr(1500, 7, 0, "R11");
        rd(1500, 0, 0, "R11");
        wr(21, 1, 0, "R11");
        rd(21, 0, 0, "R11");
        rd(22, 0, 0, "R11");
        // error pulse lasts one cycle (R12)
        wr(40, 1, 1, "R12");
        @(negedge clk);
        chk("R12", {31'b0, err_pulse}, 0, "pulse one cycle");
        // guest (R13)
        wr(23, 32'h0000_5008, 0, "R13");
        rd(23, 32'h0000_5008, 0, "R13");
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule